// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a general-purpose I/O port with a parameterized number of pins (16 by default) behind a small register bus. Software sets each pin through four registers: a direction register, an output latch, a per-pin open-drain select and a per-pin digital-enable select. For every pin the block drives a tri-state pad model, made of an output value and an output-enable, and it receives the sampled pad level. Pins with digital-enable clear are analog. They read back as zero on the port register, and they are routed to the converter only while their direction is input.

The pad levels pass through a synchronizer chain before they reach the port read path. A write to the direction or latch register therefore shows up on a port read only after a fixed number of cycles. A read returns the level at the pad, not the latch contents.

Bus reads are registered. The read path is controlled by a two-state machine:

- In `RD_IDLE`, a read strobe takes the machine to `RD_RESP`, which is the read-issued transition. With no strobe it stays in `RD_IDLE`, which is the idle hold.
- In `RD_RESP`, another strobe keeps it in `RD_RESP`, which is the back-to-back transition. With no strobe it goes back to `RD_IDLE`, which is the response-done transition.
- `bus_rvalid` is high exactly while the machine is in `RD_RESP`.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset:
  - the direction register is all ones (all inputs);
  - the latch and the open-drain select are zero;
  - the digital-enable select is zero (all pins analog);
  - `pad_oe` is zero and `bus_rvalid` is low.
- R2: Register addresses are 0 direction, 1 latch, 2 port, 3 open-drain select and 4 digital-enable select. A write (`bus_wr_en` high at a rising edge) updates the addressed register at that edge. Reads of addresses 0, 1, 3 and 4 return the register contents. Reads of addresses 5 to 7 return zero.
- R3: A write to address 2 (port) updates the output latch.
- R4: A pin with direction 0 and open-drain select 0 is push-pull: `pad_oe` is 1 and `pad_out` equals the latch bit.
- R5: A pin with direction 0 and open-drain select 1 only pulls low:
  - when its latch bit is 0, `pad_oe` is 1 and `pad_out` is 0;
  - when its latch bit is 1, `pad_oe` is 0.
- R6: A pin with direction 1 is never driven (`pad_oe` 0), whatever its latch and open-drain bits are.
- R7: A read strobe sampled at edge E puts the read data on `bus_rdata` and raises `bus_rvalid` in the cycle after E. `bus_rvalid` is low in any cycle that follows an edge with no strobe.
- R8: A read of address 2 returns the synchronized pad level for pins whose digital-enable bit is 1. It returns 0 for every analog pin (digital-enable 0), whatever the pad level.
- R9: A pad level that is stable at edge P is returned by port reads sampled at edge P+SYNC_STAGES or later. A port read sampled at the first edge after a latch or direction write returns the level from before the write.
- R10: A read of address 1 returns the latch contents, even where the pad level differs.
- R11: `adc_route` is 1 exactly for pins that are analog (digital-enable 0) and set as input (direction 1). It is never 1 on a driven pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| pad_in | input | 16 | Sampled pad levels |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output-enable |
| adc_route | output | 16 | Pin routed to the converter as analog input |

## Verification
The bench builds the block with its defaults, WIDTH = 16 and SYNC_STAGES = 2.

The full width lets a single pattern mix push-pull, open-drain, released, input and analog pins. This makes one port read test drive resolution and analog masking together.

With a two-stage chain, the stale read at the first edge after a write and the fresh read two edges later are only a few cycles apart. The bench can therefore pin both of them to exact edges through a pad loopback.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 3'd0,
        REG_LAT  = 3'd1,
        REG_PORT = 3'd2,
        REG_ODC  = 3'd3,
        REG_DSEL = 3'd4
    } reg_sel_e;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  odc_q,
    output logic [WIDTH-1:0]  dsel_q
);
    logic wr_dir, wr_lat, wr_odc, wr_dsel;

    always_comb begin
        wr_dir  = 1'b0;
        wr_lat  = 1'b0;
        wr_odc  = 1'b0;
        wr_dsel = 1'b0;
        if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_DIR:  wr_dir  = 1'b1;
                REG_LAT,
                REG_PORT: wr_lat  = 1'b1;
                REG_ODC:  wr_odc  = 1'b1;
                REG_DSEL: wr_dsel = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            lat_q  <= '0;
            odc_q  <= '0;
            dsel_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wdata;
            if (wr_lat)  lat_q  <= wdata;
            if (wr_odc)  odc_q  <= wdata;
            if (wr_dsel) dsel_q <= wdata;
        end
    end

    AST_DIR_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> (dir_q == $past(wdata))); // R2
    AST_PORT_WRITE_HITS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_PORT) |=> (lat_q == $past(wdata))); // R3
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] odc_q,
    input  logic [WIDTH-1:0] dsel_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] adc_route
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic is_output;
        assign is_output = ~dir_q[p];
        always_comb begin
            if (odc_q[p]) begin
                pad_out[p] = 1'b0;
                pad_oe[p]  = is_output & ~lat_q[p];
            end else begin
                pad_out[p] = lat_q[p];
                pad_oe[p]  = is_output;
            end
        end
        assign adc_route[p] = dir_q[p] & ~dsel_q[p];
    end

    AST_INPUT_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & dir_q) == '0)); // R6
    AST_OD_NEVER_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & odc_q & pad_out) == '0)); // R5
    AST_PUSHPULL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~odc_q & ~pad_oe) == '0)); // R4
endmodule

// File: rtl/gpio_rdpath.sv
module gpio_rdpath
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic [WIDTH-1:0]  pad_in,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  lat_q,
    input  logic [WIDTH-1:0]  odc_q,
    input  logic [WIDTH-1:0]  dsel_q,
    output logic [WIDTH-1:0]  rdata,
    output logic              rvalid
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] sync_q [SYNC_STAGES];
    logic [WIDTH-1:0] port_view;
    logic [WIDTH-1:0] mux_val;
    rd_state_e        state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= pad_in;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    assign port_view = sync_q[LAST] & dsel_q;

    always_comb begin
        case (reg_sel_e'(addr))
            REG_DIR:  mux_val = dir_q;
            REG_LAT:  mux_val = lat_q;
            REG_PORT: mux_val = port_view;
            REG_ODC:  mux_val = odc_q;
            REG_DSEL: mux_val = dsel_q;
            default:  mux_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_en)  state_d = RD_RESP;
            RD_RESP: if (!rd_en) state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mux_val;
    end

    assign rvalid = (state_q == RD_RESP);

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid); // R7
    AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid); // R7
    AST_ANALOG_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_PORT) |=> ((rdata & ~$past(dsel_q)) == '0)); // R8
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  adc_route
);
    logic [WIDTH-1:0] dir_q, lat_q, odc_q, dsel_q;

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr_en  (bus_wr_en),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .lat_q  (lat_q),
        .odc_q  (odc_q),
        .dsel_q (dsel_q)
    );

    gpio_drive #(.WIDTH(WIDTH)) i_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .odc_q     (odc_q),
        .dsel_q    (dsel_q),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .adc_route (adc_route)
    );

    gpio_rdpath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_rdpath (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .rd_en  (bus_rd_en),
        .pad_in (pad_in),
        .dir_q  (dir_q),
        .lat_q  (lat_q),
        .odc_q  (odc_q),
        .dsel_q (dsel_q),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    AST_ADC_NOT_ON_DRIVEN_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((adc_route & pad_oe) == '0)); // R11
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] pad_in, pad_out, pad_oe, adc_route;
    logic [15:0] ext_lvl = 16'hFFFF;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    for (genvar p = 0; p < 16; p++) begin : g_loop
        assign pad_in[p] = pad_oe[p] ? pad_out[p] : ext_lvl[p];
    end

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .adc_route(adc_route)
    );

    // {dir, lat, odc, dsel, ext, exp_oe, exp_out, exp_port, exp_adc}
    localparam logic [143:0] VEC [5] = '{
        {16'h0000, 16'hA5A5, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hA5A5, 16'hA5A5, 16'h0000},
        {16'hFFFF, 16'h1234, 16'h0000, 16'hFFFF, 16'h5A5A, 16'h0000, 16'h1234, 16'h5A5A, 16'h0000},
        {16'h0000, 16'h00FF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFF00, 16'h0000, 16'h00FF, 16'h0000},
        {16'hFF00, 16'h0F0F, 16'h0000, 16'h0FF0, 16'h3C3C, 16'h00FF, 16'h0F0F, 16'h0C00, 16'hF000},
        {16'h0000, 16'hF0F0, 16'hFF00, 16'h00FF, 16'hAAAA, 16'h0FFF, 16'h00F0, 16'h00F0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Caller sits at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d, output logic v);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual=hung expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        logic        v;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 16'h0000);
        chk("R1 rvalid", {15'd0, bus_rvalid}, 16'h0000);
        chk("R11 adc_route at reset", adc_route, 16'hFFFF);
        rd(3'd0, d, v); chk("R1 dir", d, 16'hFFFF); chk("R7 rvalid", {15'd0, v}, 16'h0001);
        rd(3'd1, d, v); chk("R1 lat", d, 16'h0000);
        rd(3'd3, d, v); chk("R1 odc", d, 16'h0000);
        rd(3'd4, d, v); chk("R1 dsel", d, 16'h0000);
        idle(3);
        rd(3'd2, d, v); chk("R8 analog port reads zero", d, 16'h0000);
        idle(1);
        chk("R7 rvalid low when idle", {15'd0, bus_rvalid}, 16'h0000);

        // Vector walk: R4 R5 R6 R8 R11
        for (int k = 0; k < 5; k++) begin
            logic [143:0] e;
            e = VEC[k];
            ext_lvl = e[79:64];
            wr(3'd0, e[143:128]);
            wr(3'd1, e[127:112]);
            wr(3'd3, e[111:96]);
            wr(3'd4, e[95:80]);
            idle(4);
            chk("R4/R5/R6 pad_oe", pad_oe, e[63:48]);
            chk("R4/R5 pad_out", pad_out, e[47:32]);
            chk("R11 adc_route", adc_route, e[15:0]);
            rd(3'd2, d, v);
            chk("R8 port read", d, e[31:16]);
        end

        // R2 readback and unmapped addresses
        wr(3'd3, 16'h6C93);
        rd(3'd3, d, v); chk("R2 odc readback", d, 16'h6C93);
        rd(3'd5, d, v); chk("R2 addr5 zero", d, 16'h0000);
        rd(3'd7, d, v); chk("R2 addr7 zero", d, 16'h0000);

        // R3 write via port address, R10 latch read differs from pad
        wr(3'd0, 16'hFFFF);
        wr(3'd4, 16'hFFFF);
        ext_lvl = 16'h0000;
        wr(3'd2, 16'h1357);
        rd(3'd1, d, v); chk("R3 R10 latch via port addr", d, 16'h1357);
        idle(3);
        rd(3'd2, d, v); chk("R10 port shows pad not latch", d, 16'h0000);

        // R9 latency through synchronizer
        wr(3'd3, 16'h0000);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0000);
        idle(4);
        wr(3'd1, 16'hFFFF);
        rd(3'd2, d, v); chk("R9 next-cycle read stale", d, 16'h0000);
        chk("R7 rvalid on stale read", {15'd0, v}, 16'h0001);
        idle(1);
        rd(3'd2, d, v); chk("R9 settled read", d, 16'hFFFF);

        // R7 back-to-back reads keep rvalid
        bus_addr = 3'd1; bus_rd_en = 1'b1;
        @(negedge clk);
        chk("R7 rvalid b2b first", {15'd0, bus_rvalid}, 16'h0001);
        bus_addr = 3'd0;
        @(negedge clk);
        bus_rd_en = 1'b0;
        chk("R7 rvalid b2b second", {15'd0, bus_rvalid}, 16'h0001);
        chk("R7 b2b data", bus_rdata, 16'h0000);
        @(negedge clk);
        chk("R7 rvalid drops", {15'd0, bus_rvalid}, 16'h0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule